// File: doc/BRIEF.md
# Memory-Mapped Vectored Interrupt Controller

This block gathers up to 32 interrupt lines into one processor request. A rising edge on any line is latched into a status word and stays there until software acknowledges it. A per-line enable word masks the latched bits, and the masked result is called the pending word. A fixed-priority encoder turns the pending word into a vector index, and the lowest-numbered line wins. The processor interrupt output is gated by two control bits: a master enable that software can clear, and a hardware enable that stays set once written.

Software reaches every register through a single-cycle 32-bit bus. A write commits on the clock edge on which `bus_sel` and `bus_we` are both high. Read data is combinational from the current register state. Besides the status, enable and control words, the register file has a mode word and a table of per-line handler addresses. The mode word is storage only and drives no logic here. Typical use: software loads the handler table, enables lines through the set and clear aliases, and turns on both control bits. In the handler it reads the vector, services the line, then writes the matching bit to the acknowledge register.

Top module: `vic_top`

## Requirements
- R1: A 0-to-1 transition on `irq_src[i]` sets status bit i (offset 0x00) on that clock edge. The bit then holds until acknowledged. An input that stays high does not set the bit again after it has been acknowledged.
- R2: Writing to the acknowledge register (0x0C) clears every status bit written as 1. If a new edge on a line arrives in the same cycle as the write that acknowledges it, the status bit stays set. Writing all ones clears every line that has no new edge.
- R3: The enable register (0x08) reads back the last value written to it directly.
- R4: Writing to the set-enable alias (0x10) sets each enable bit written as 1 and leaves the others unchanged.
- R5: Writing to the clear-enable alias (0x14) clears each enable bit written as 1 and leaves the others unchanged.
- R6: The pending register (0x04) reads as status AND enable, bit by bit. Writes to it have no effect.
- R7: The vector register (0x18) reads the index of the lowest-numbered pending bit, zero-extended. It reads 0xFFFFFFFF when no bit is pending.
- R8: In the control register (0x1C), bit 0 is the master enable and is freely writable. Bit 1 is the hardware enable: once written to 1 it stays 1 until reset, whatever is written later.
- R9: `irq_out` is 1 exactly when control bits 0 and 1 are both set and at least one pending bit is 1.
- R10: Handler-table entry i sits at 0x100 + 4*i, is readable and writable, and resets to 0x10. The mode register (0x20) is readable and writable.
- R11: Reads of the acknowledge, set-enable and clear-enable offsets, and of unmapped offsets, return 0. Writes to the status, pending and vector offsets are ignored.
- R12: After reset, status, enable, control and mode read 0, the vector reads 0xFFFFFFFF and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Interrupt input lines, rising-edge sensitive |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Edge capture and the acknowledge write can both act on the same status bit in the same clock cycle. This is the collision that decides whether an interrupt is lost. The bench provokes it by raising a line on the same negative edge on which it places an acknowledge write for that line, so both are seen at the following rising edge. It then reads the status word and expects the bit still set. It checks that a second, uncontended acknowledge clears the bit, to show that the first write was judged correctly rather than ignored.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int OFS_STAT = 'h000;
  localparam int OFS_PEND = 'h004;
  localparam int OFS_EN   = 'h008;
  localparam int OFS_ACK  = 'h00C;
  localparam int OFS_SET  = 'h010;
  localparam int OFS_CLR  = 'h014;
  localparam int OFS_VEC  = 'h018;
  localparam int OFS_CTL  = 'h01C;
  localparam int OFS_MODE = 'h020;
  localparam int OFS_TAB  = 'h100;
endpackage

// File: rtl/vic_edge_capture.sv
module vic_edge_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] ack_mask,
  output logic [N-1:0] status,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q, status_q;

  function automatic logic [N-1:0] next_status(input logic [N-1:0] cur,
                                               input logic [N-1:0] clr,
                                               input logic [N-1:0] setb);
    return (cur & ~clr) | setb;
  endfunction

  assign rise   = src & ~prev_q;
  assign status = status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= src;
      status_q <= next_status(status_q, ack_mask, rise);
    end
  end

  p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((status_q & $past(rise)) == $past(rise)));

  p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_mask & ~rise) != '0) |=> ((status_q & $past(ack_mask & ~rise)) == '0));
endmodule

// File: rtl/vic_enable.sv
module vic_enable #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_direct,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en
);
  logic [N-1:0] en_q;

  function automatic logic [N-1:0] apply(input logic [N-1:0] cur, input logic [N-1:0] d,
                                         input logic dir, input logic s, input logic c);
    logic [N-1:0] r;
    r = dir ? d : cur;
    if (s) r = r | d;
    if (c) r = r & ~d;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= apply(en_q, wdata, wr_direct, wr_set, wr_clr);
  end

  assign en = en_q;

  p_set_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(wdata)) == $past(wdata)));

  p_clr_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(wdata)) == '0));

  p_set_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend,
  output logic          vld,
  output logic [IW-1:0] idx
);
  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign vld = |pend;
  assign idx = lowest_set(pend);

  p_vec_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (pend[idx] && ((pend & ((N'(1) << idx) - N'(1))) == '0)));
endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int          NUM_SRC   = 32,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] VEC_RESET = 32'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  import vic_pkg::*;

  localparam int IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int TAB_END = OFS_TAB + 4 * NUM_SRC;

  logic               wr, rd;
  logic               wr_en, wr_set, wr_clr, wr_ack, wr_ctl, wr_mode, wr_tab;
  logic [NUM_SRC-1:0] ack_mask, status, rise, enable, pending, mode_q;
  logic               tab_hit, prio_vld, me_q, he_q;
  logic [IW-1:0]      tab_idx, prio_idx;
  logic [31:0]        vtab [NUM_SRC];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign tab_hit = (32'(bus_addr) >= OFS_TAB) && (32'(bus_addr) < TAB_END);
  assign tab_idx = IW'((32'(bus_addr) - OFS_TAB) >> 2);
  assign wr_en   = wr & hit(bus_addr, OFS_EN);
  assign wr_set  = wr & hit(bus_addr, OFS_SET);
  assign wr_clr  = wr & hit(bus_addr, OFS_CLR);
  assign wr_ack  = wr & hit(bus_addr, OFS_ACK);
  assign wr_ctl  = wr & hit(bus_addr, OFS_CTL);
  assign wr_mode = wr & hit(bus_addr, OFS_MODE);
  assign wr_tab  = wr & tab_hit;
  assign ack_mask = wr_ack ? bus_wdata[NUM_SRC-1:0] : '0;

  vic_edge_capture #(.N(NUM_SRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .ack_mask(ack_mask),
    .status(status), .rise(rise)
  );

  vic_enable #(.N(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_direct(wr_en), .wr_set(wr_set), .wr_clr(wr_clr),
    .wdata(bus_wdata[NUM_SRC-1:0]), .en(enable)
  );

  assign pending = status & enable;

  vic_prio #(.N(NUM_SRC), .IW(IW)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pending), .vld(prio_vld), .idx(prio_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      me_q   <= 1'b0;
      he_q   <= 1'b0;
      mode_q <= '0;
    end else begin
      if (wr_ctl) begin
        me_q <= bus_wdata[0];
        he_q <= he_q | bus_wdata[1];
      end
      if (wr_mode) mode_q <= bus_wdata[NUM_SRC-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_tab
    always_ff @(posedge clk) begin
      if (!rst_n)                                vtab[g] <= VEC_RESET;
      else if (wr_tab && tab_idx == IW'(g))      vtab[g] <= bus_wdata;
    end
  end

  assign irq_out = me_q & he_q & prio_vld;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if      (hit(bus_addr, OFS_STAT)) bus_rdata = 32'(status);
      else if (hit(bus_addr, OFS_PEND)) bus_rdata = 32'(pending);
      else if (hit(bus_addr, OFS_EN))   bus_rdata = 32'(enable);
      else if (hit(bus_addr, OFS_VEC))  bus_rdata = prio_vld ? 32'(prio_idx) : '1;
      else if (hit(bus_addr, OFS_CTL))  bus_rdata = {30'd0, he_q, me_q};
      else if (hit(bus_addr, OFS_MODE)) bus_rdata = 32'(mode_q);
      else if (tab_hit)                 bus_rdata = vtab[tab_idx];
    end
  end

  p_hw_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    he_q |=> he_q);

  p_irq_needs_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pending[prio_idx] && me_q));

  p_wo_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (hit(bus_addr, OFS_ACK) || hit(bus_addr, OFS_SET) || hit(bus_addr, OFS_CLR)))
      |-> (bus_rdata == '0));
endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
  localparam int N = 32;
  localparam logic [11:0] A_STAT = 12'h000, A_PEND = 12'h004, A_EN = 12'h008,
    A_ACK = 12'h00C, A_SET = 12'h010, A_CLR = 12'h014, A_VEC = 12'h018,
    A_CTL = 12'h01C, A_MODE = 12'h020, A_TAB = 12'h100;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_src = '0;
  logic bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_out;
  int total = 0, bad = 0;

  vic_top dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); irq_src = irq_src | m;
    @(negedge clk); irq_src = irq_src & ~m;
  endtask

  task automatic t_reset;
    rdchk("R12 status", A_STAT, 0);
    rdchk("R12 enable", A_EN, 0);
    rdchk("R12 vector", A_VEC, 32'hFFFF_FFFF);
    rdchk("R12 control", A_CTL, 0);
    rdchk("R12 mode", A_MODE, 0);
    chk("R12 irq_out", 32'(irq_out), 0);
    rdchk("R10 table[0] reset", A_TAB, 32'h10);
    rdchk("R10 table[31] reset", A_TAB + 12'd124, 32'h10);
  endtask

  task automatic t_edge;
    pulse(32'h88);
    rdchk("R1 two edges latched", A_STAT, 32'h88);
    @(negedge clk); irq_src[5] = 1'b1;
    @(negedge clk);
    rdchk("R1 level line latched", A_STAT, 32'hA8);
    wr(A_ACK, 32'h20);
    rdchk("R1 held level not relatched after ack", A_STAT, 32'h88);
    @(negedge clk); irq_src[5] = 1'b0;
  endtask

  task automatic t_enable;
    wr(A_EN, 32'hF0);
    rdchk("R3 direct enable", A_EN, 32'hF0);
    wr(A_SET, 32'h03);
    rdchk("R4 set alias", A_EN, 32'hF3);
    wr(A_CLR, 32'h30);
    rdchk("R5 clear alias", A_EN, 32'hC3);
    rdchk("R11 set alias reads zero", A_SET, 0);
    rdchk("R11 clear alias reads zero", A_CLR, 0);
    rdchk("R11 ack reads zero", A_ACK, 0);
  endtask

  task automatic t_pending;
    rdchk("R6 pending and", A_PEND, 32'h80);
    wr(A_PEND, 32'hFFFF_FFFF);
    rdchk("R6 pending write ignored", A_PEND, 32'h80);
    wr(A_STAT, 32'h0);
    rdchk("R11 status write ignored", A_STAT, 32'h88);
    rdchk("R7 vector bit7", A_VEC, 7);
    wr(A_SET, 32'h08);
    rdchk("R7 lowest wins", A_VEC, 3);
  endtask

  task automatic t_irq;
    chk("R9 irq off, control clear", 32'(irq_out), 0);
    wr(A_CTL, 32'h1);
    chk("R9 irq off without hw enable", 32'(irq_out), 0);
    wr(A_CTL, 32'h3);
    chk("R9 irq on", 32'(irq_out), 1);
    rdchk("R8 control readback", A_CTL, 3);
    wr(A_CTL, 32'h0);
    rdchk("R8 hw enable sticky", A_CTL, 2);
    chk("R9 irq off, master clear", 32'(irq_out), 0);
    wr(A_CTL, 32'h1);
    chk("R9 irq on again", 32'(irq_out), 1);
  endtask

  task automatic t_ack_race;
    @(negedge clk);
    irq_src[3] = 1'b1;
    bus_sel = 1; bus_we = 1; bus_addr = A_ACK; bus_wdata = 32'h08;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; irq_src[3] = 1'b0;
    rdchk("R2 edge beats ack", A_STAT, 32'h88);
    wr(A_ACK, 32'h08);
    rdchk("R2 plain ack clears", A_STAT, 32'h80);
    wr(A_ACK, 32'hFFFF_FFFF);
    rdchk("R2 ack all", A_STAT, 0);
    rdchk("R7 empty vector", A_VEC, 32'hFFFF_FFFF);
    chk("R9 irq off when nothing pending", 32'(irq_out), 0);
  endtask

  task automatic t_extremes;
    wr(A_EN, 32'hFFFF_FFFF);
    pulse(32'h8000_0000);
    rdchk("R7 top line", A_VEC, 31);
    chk("R9 irq from top line", 32'(irq_out), 1);
    pulse(32'h1);
    rdchk("R7 line 0 highest", A_VEC, 0);
    wr(A_VEC, 32'h5);
    rdchk("R11 vector write ignored", A_VEC, 0);
  endtask

  task automatic t_tables;
    wr(A_TAB + 12'd20, 32'hABCD_1234);
    rdchk("R10 table[5] write", A_TAB + 12'd20, 32'hABCD_1234);
    rdchk("R10 table[4] untouched", A_TAB + 12'd16, 32'h10);
    wr(A_MODE, 32'h5);
    rdchk("R10 mode readback", A_MODE, 32'h5);
    rdchk("R11 unmapped reads zero", 12'h040, 0);
    rdchk("R11 past table reads zero", 12'h180, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_edge();
    t_enable();
    t_pending();
    t_irq();
    t_ack_race();
    t_extremes();
    t_tables();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule